// File: doc/BRIEF.md
# SHA-256 Two-Round Compression Step

This block advances a SHA-256 working state by two rounds. The eight state words arrive split across two 128-bit operands. The first operand carries A, B, E and F, and the second carries C, D, G and H. A third 128-bit operand carries words in which the message word and the round constant have already been added. The block returns only the new A, B, E and F, packed in the same layout as the first operand. Producing the message schedule, the constant table, the padding and the final digest addition is left to the surrounding logic.

Operands enter through a valid/ready handshake, and the result leaves through a second valid/ready handshake. A transfer takes place on a rising edge where valid and ready are both high. `in_ready` is high only while the block is idle. After an operand is accepted, `in_ready` stays low until the result has been taken. A producer may hold `in_valid` high at any time, and nothing is captured while `in_ready` is low. The consumer applies back-pressure by keeping `out_ready` low. The result then stays frozen on `out_abef`, with `out_valid` high, for as long as the consumer waits.

The block has one round datapath, and it evaluates one round per clock. The first round is computed directly from the operand ports on the acceptance edge. Each remaining round uses the registered state and the stored constant words.

Top module: `sha256_dual_round`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 only when no operation is in flight. From the cycle after acceptance until the result has been taken, `in_ready` is 0 and `in_valid` is ignored.
- R3: `out_valid` rises exactly two clock edges after the acceptance edge, and it is 0 on the cycle in between.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_abef` holds its value.
- R5: On the cycle after a result handshake, `out_valid` is 0 and `in_ready` is 1.
- R6: Each round computes T = Ch(E,F,G) + Σ1(E) + WK + H, with Ch = (E&F)^(~E&G) and Σ1 = rotr6^rotr11^rotr25. The new A is T + Maj(A,B,C) + Σ0(A), with Maj = (A&B)^(A&C)^(B&C) and Σ0 = rotr2^rotr13^rotr22. The new E is T + D. The other words shift as B←A, C←B, D←C, F←E, G←F and H←G.
- R7: On the input side, `in_abef` bits 127:96, 95:64, 63:32 and 31:0 hold A, B, E and F. `in_cdgh` holds C, D, G and H in the same four bit ranges.
- R8: Round one uses `in_wk` bits 31:0, and round two uses bits 63:32. Bits 127:64 have no effect on the result.
- R9: `out_abef` holds A in bits 127:96, B in 95:64, E in 63:32 and F in 31:0, taken after the second round.
- R10: Every addition wraps modulo 2^32.
- R11: Changes on `in_abef`, `in_cdgh` and `in_wk` after the acceptance edge do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set is presented |
| in_ready | output | 1 | Block is idle and will accept operands |
| in_abef | input | 128 | State words A, B, E, F |
| in_cdgh | input | 128 | State words C, D, G, H |
| in_wk | input | 128 | Pre-added message-plus-constant words |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| out_abef | output | 128 | Updated A, B, E, F after two rounds |

## Verification
The handshake assertions rely on `out_ready` being an ordinary synchronous input. They place no limit on how long the consumer stalls, and they allow `in_valid` to be high while the block is busy. The stimulus exercises both freedoms. It drives random stall lengths, keeps `in_valid` high with junk operands during busy cycles, and scrambles the data ports right after acceptance. It also drives random state words and random constant words, including random values in the unused upper lanes. A few directed cases add all-zero and all-one operands, which force carries through every adder.

// File: rtl/sha2r_pkg.sv
package sha2r_pkg;

  localparam int LANE_W = 32;
  localparam int LANES  = 4;
  localparam int OP_W   = LANE_W * LANES;

  typedef logic [LANE_W-1:0] word_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t e;
    word_t f;
    word_t g;
    word_t h;
  } st8_t;

  typedef enum logic [1:0] {
    C_IDLE = 2'd0,
    C_RUN  = 2'd1,
    C_HOLD = 2'd2
  } cst_t;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (LANE_W - n));
  endfunction

  function automatic word_t f_ch(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t f_maj(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

  function automatic word_t big_sig0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_sig1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

endpackage

// File: rtl/sha2r_round.sv
module sha2r_round
  import sha2r_pkg::*;
(
  input  st8_t  cur,
  input  word_t wk,
  output st8_t  nxt
);

  word_t t_sum;
  word_t a_sum;

  // R6: T and the new A; all sums truncate to the word width (R10)
  always_comb begin
    t_sum = f_ch(cur.e, cur.f, cur.g) + big_sig1(cur.e) + wk + cur.h;
    a_sum = t_sum + f_maj(cur.a, cur.b, cur.c) + big_sig0(cur.a);
  end

  always_comb begin
    nxt.a = a_sum;
    nxt.b = cur.a;
    nxt.c = cur.b;
    nxt.d = cur.c;
    nxt.e = t_sum + cur.d;
    nxt.f = cur.e;
    nxt.g = cur.f;
    nxt.h = cur.g;
  end

endmodule

// File: rtl/sha2r_ctrl.sv
module sha2r_ctrl
  import sha2r_pkg::*;
#(
  parameter int ROUNDS = 2,
  parameter int CNT_W  = $clog2(ROUNDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             accept,
  output logic             step,
  output logic [CNT_W-1:0] rnd
);

  cst_t             st_q;
  logic [CNT_W-1:0] rnd_q;

  assign in_ready  = (st_q == C_IDLE);
  assign out_valid = (st_q == C_HOLD);
  assign accept    = in_valid && in_ready;
  assign step      = (st_q == C_RUN);
  assign rnd       = rnd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= C_IDLE;
      rnd_q <= '0;
    end else begin
      case (st_q)
        C_IDLE: if (accept) begin
          rnd_q <= CNT_W'(1);
          st_q  <= (ROUNDS == 1) ? C_HOLD : C_RUN;
        end
        C_RUN: begin
          rnd_q <= rnd_q + CNT_W'(1);
          if (rnd_q == CNT_W'(ROUNDS - 1)) st_q <= C_HOLD;
        end
        C_HOLD: if (out_ready) st_q <= C_IDLE;
        default: st_q <= C_IDLE;
      endcase
    end
  end

  // R5: a taken result frees the block on the next cycle
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && in_ready);

endmodule

// File: rtl/sha256_dual_round.sv
module sha256_dual_round
  import sha2r_pkg::*;
#(
  parameter int ROUNDS = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [127:0]   in_abef,
  input  logic [127:0]   in_cdgh,
  input  logic [127:0]   in_wk,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [127:0]   out_abef
);

  localparam int CNT_W = $clog2(ROUNDS + 1);

  logic             accept;
  logic             step;
  logic [CNT_W-1:0] rnd;

  st8_t             in_st;
  st8_t             state_q;
  st8_t             rnd_in;
  st8_t             rnd_out;
  word_t            wk_sel;
  logic [OP_W-1:0]  wk_q;

  sha2r_ctrl #(.ROUNDS(ROUNDS), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .accept    (accept),
    .step      (step),
    .rnd       (rnd)
  );

  // R7: operand lane layout
  always_comb begin
    in_st.a = in_abef[4*LANE_W-1:3*LANE_W];
    in_st.b = in_abef[3*LANE_W-1:2*LANE_W];
    in_st.e = in_abef[2*LANE_W-1:LANE_W];
    in_st.f = in_abef[LANE_W-1:0];
    in_st.c = in_cdgh[4*LANE_W-1:3*LANE_W];
    in_st.d = in_cdgh[3*LANE_W-1:2*LANE_W];
    in_st.g = in_cdgh[2*LANE_W-1:LANE_W];
    in_st.h = in_cdgh[LANE_W-1:0];
  end

  // First round runs straight off the ports; later ones from stored state (R8)
  always_comb begin
    rnd_in = accept ? in_st : state_q;
    wk_sel = in_wk[LANE_W-1:0];
    if (!accept) begin
      for (int i = 0; i < LANES; i++) begin
        if (rnd == CNT_W'(i)) wk_sel = wk_q[i*LANE_W +: LANE_W];
      end
    end
  end

  sha2r_round u_round (
    .cur (rnd_in),
    .wk  (wk_sel),
    .nxt (rnd_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      wk_q    <= '0;
    end else begin
      if (accept || step) state_q <= rnd_out;
      if (accept) wk_q <= in_wk;
    end
  end

  // R9: result packing
  assign out_abef = {state_q.a, state_q.b, state_q.e, state_q.f};

  // Cycle counter from acceptance, used only to check latency
  logic [CNT_W-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else if (accept) lat_q <= CNT_W'(1);
    else if (!in_ready && !out_valid) lat_q <= lat_q + CNT_W'(1);
  end

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat_q == CNT_W'(ROUNDS));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  a_r4_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_abef));

endmodule

// File: tb/sim_sha256_dual_round.sv
`timescale 1ns/1ps
module sim_sha256_dual_round;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_abef = '0;
  logic [127:0] in_cdgh = '0;
  logic [127:0] in_wk = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_abef;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sha256_dual_round u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_abef(in_abef), .in_cdgh(in_cdgh), .in_wk(in_wk),
    .out_valid(out_valid), .out_ready(out_ready), .out_abef(out_abef)
  );

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [127:0] ref_f(input logic [127:0] x, y, w);
    logic [31:0] a, b, c, d, e, f, g, h, t, na, ne;
    a = x[127:96]; b = x[95:64]; e = x[63:32]; f = x[31:0];
    c = y[127:96]; d = y[95:64]; g = y[63:32]; h = y[31:0];
    for (int n = 0; n < 2; n++) begin
      t  = ((e & f) ^ (~e & g)) + (rr(e,6) ^ rr(e,11) ^ rr(e,25)) + w[n*32 +: 32] + h;
      na = t + ((a & b) ^ (a & c) ^ (b & c)) + (rr(a,2) ^ rr(a,13) ^ rr(a,22));
      ne = t + d;
      h = g; g = f; f = e; e = ne;
      d = c; c = b; b = a; a = na;
    end
    return {a, b, e, f};
  endfunction

  function automatic logic [127:0] r128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [127:0] x, y, w, input int hold,
                       input bit scramble, input string tag,
                       output logic [127:0] got);
    logic [127:0] exp;
    exp = ref_f(x, y, w);
    @(negedge clk);
    chk(in_ready === 1'b1, "R2 idle ready", {127'd0, in_ready}, 128'd1);
    in_abef = x; in_cdgh = y; in_wk = w; in_valid = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b0, "R2 busy", {127'd0, in_ready}, 128'd0);
    chk(out_valid === 1'b0, "R3 mid", {127'd0, out_valid}, 128'd0);
    in_valid = scramble;
    if (scramble) begin
      in_abef = r128(); in_cdgh = r128(); in_wk = r128();  // R11
    end
    @(negedge clk);
    chk(out_valid === 1'b1, "R3 valid", {127'd0, out_valid}, 128'd1);
    chk(out_abef === exp, tag, out_abef, exp);
    got = out_abef;
    for (int k = 0; k < hold; k++) begin
      if (scramble) begin in_abef = r128(); in_wk = r128(); end
      @(negedge clk);
      chk(out_valid === 1'b1 && out_abef === exp, "R4 hold", out_abef, exp);
      chk(in_ready === 1'b0, "R2 stall", {127'd0, in_ready}, 128'd0);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R5 release",
        {126'd0, out_valid, in_ready}, 128'd1);
    out_ready = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] g1, g2, w1, w2, x, y;
    void'($urandom(32'h5eed_2561));
    repeat (2) @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R1 in reset",
        {126'd0, out_valid, in_ready}, 128'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R1 after reset",
        {126'd0, out_valid, in_ready}, 128'd1);

    // Directed: zeros, all ones (R10 carries), distinct lanes (R7, R9)
    do_op('0, '0, '0, 0, 1'b0, "R6 zeros", g1);
    do_op({128{1'b1}}, {128{1'b1}}, {128{1'b1}}, 1, 1'b0, "R10 all ones", g1);
    do_op({32'h6a09e667, 32'hbb67ae85, 32'h510e527f, 32'h9b05688c},
          {32'h3c6ef372, 32'ha54ff53a, 32'h1f83d9ab, 32'h5be0cd19},
          {64'h0, 32'h71374491, 32'h428a2f98}, 2, 1'b1, "R7/R9 lanes", g1);

    // R8: upper constant lanes make no difference
    x = r128(); y = r128(); w1 = r128(); w2 = w1;
    w2[127:64] = ~w1[127:64];
    do_op(x, y, w1, 0, 1'b0, "R8 upper lanes a", g1);
    do_op(x, y, w2, 0, 1'b0, "R8 upper lanes b", g2);
    chk(g1 === g2, "R8 same result", g2, g1);

    // Random ops with stalls and post-acceptance scrambling (R6, R11)
    for (int i = 0; i < 60; i++) begin
      do_op(r128(), r128(), r128(), int'($urandom % 4), 1'(i % 2), "R6/R11 random", g1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule